// File: doc/BRIEF.md
# UART Interrupt Source Collector

This unit gathers the three interrupt causes of a UART and turns them into one interrupt request. The causes are the receive FIFO filling up to its trigger level, the receive FIFO holding data that has gone stale, and the transmit FIFO draining down to its trigger level. The FIFO fill levels, the two trigger-level selects and a strobe from the receive idle timer all come in as plain inputs. The unit keeps a sticky raw status bit per cause, an enable mask and the masked view. It drives one combined request line and three FIFO flags.

Software enables causes through a mask write and acknowledges them through a clear write. A clear write carries a vector, and each 1 in it drops the matching raw bit. The usual handler writes back the masked status it has just read. The receive and transmit causes fire on the cycle that a level crosses its trigger, not for as long as the level stays past it. A transmit FIFO that is already low therefore raises nothing when its enable bit is turned on.

Top module: `uart_irq_unit`

## Requirements
- R1: Status and mask vectors use bit 0 for receive-level, bit 1 for receive-timeout and bit 2 for transmit-level. After reset the raw status, the mask and `irq` are all 0.
- R2: A level select of 0, 1, 2, 3 or 4 places the trigger at 1/8, 1/4, 1/2, 3/4 or 7/8 of `FIFO_DEPTH`. Selects 5 to 7 place it at 1/2.
- R3: Raw bit 0 sets in the cycle after `rxLevel >= trigger` becomes true when it was false in the previous cycle. It stays set until it is cleared.
- R4: Raw bit 2 sets in the cycle after `txLevel <= trigger` becomes true when it was false in the previous cycle. Out of reset the condition counts as already true, so a FIFO that stays low raises nothing, even once its mask bit is set.
- R5: Raw bit 1 sets in the cycle after `rxIdleStrobe` is seen while `rxLevel` is nonzero. It clears in the cycle after `rxLevel` is 0, and a strobe while `rxLevel` is 0 has no effect.
- R6: A cycle with `clrWrEn` clears, on the next edge, every raw bit that is 1 in `clrWrData` and leaves the other raw bits unchanged.
- R7: If a raw bit's set event and its clear fall in the same cycle, the bit ends up set.
- R8: `maskedStatus` is the raw status ANDed with the mask, and `irq` is 1 exactly when any masked bit is 1.
- R9: Writing a zero mask forces `irq` low without changing the raw status.
- R10: `txFull` is 1 when `txLevel == FIFO_DEPTH`, `txEmpty` is 1 when `txLevel == 0`, and `rxEmpty` is 1 when `rxLevel == 0`.
- R11: A cycle with `maskWrEn` loads all three mask bits from `maskWrData`, and the new mask is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | LVL_W | Receive FIFO fill count |
| txLevel | input | LVL_W | Transmit FIFO fill count |
| rxSel | input | 3 | Receive trigger-level select |
| txSel | input | 3 | Transmit trigger-level select |
| rxIdleStrobe | input | 1 | Receive idle-timer expiry pulse |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrData | input | 3 | New mask value |
| clrWrEn | input | 1 | Clear write strobe |
| clrWrData | input | 3 | Bits to clear |
| rawStatus | output | 3 | Sticky raw status |
| maskOut | output | 3 | Current mask |
| maskedStatus | output | 3 | Raw status ANDed with mask |
| irq | output | 1 | Combined interrupt request |
| txFull | output | 1 | Transmit FIFO full |
| txEmpty | output | 1 | Transmit FIFO empty |
| rxEmpty | output | 1 | Receive FIFO empty |

## Verification
The functions that can collide are a new trigger crossing and a clear write aimed at the same status bit. A collision on the receive-level bit is forced on purpose. The receive level first drops below its trigger while bit 0 is still pending. In the next cycle the level jumps back over the trigger in the same cycle as a clear of bit 0, and the bit must read 1 afterwards. A cycle-accurate model in the bench judges this collision and the random stretch that follows, where the clears, timer strobes and level crossings land together freely.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int NUM_SRC = 3;
  localparam int RX_BIT  = 0;
  localparam int RT_BIT  = 1;
  localparam int TX_BIT  = 2;
  localparam int SEL_W   = 3;

  typedef struct packed {
    logic               loadMask;
    logic [NUM_SRC-1:0] clrVec;
    logic               rtSet;
    logic               rtDrop;
  } irqStrobe_t;

  // Trigger point in FIFO entries for a level select.
  function automatic int levelThreshold(input logic [SEL_W-1:0] sel, input int depth);
    case (sel)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (depth * 3) / 4;
      3'd4:    return (depth * 7) / 8;
      default: return depth / 2;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic               maskWrEn,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] clrWrData,
  input  logic               rxIdleStrobe,
  input  logic [LVL_W-1:0]   rxLevel,
  output irqStrobe_t         strobes
);

  logic rxHasData;
  assign rxHasData = (rxLevel != '0);

  always_comb begin
    strobes.loadMask = maskWrEn;
    strobes.clrVec   = clrWrEn ? clrWrData : '0;
    strobes.rtSet    = rxIdleStrobe && rxHasData;
    strobes.rtDrop   = !rxHasData;
  end

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobes,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [SEL_W-1:0]   rxSel,
  input  logic [SEL_W-1:0]   txSel,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irq,
  output logic               txFull,
  output logic               txEmpty,
  output logic               rxEmpty
);

  logic [NUM_SRC-1:0] rawQ;
  logic [NUM_SRC-1:0] maskQ;
  logic               rxCondQ;
  logic               txCondQ;
  logic               rxCond;
  logic               txCond;
  logic               rxEvent;
  logic               txEvent;
  int                 rxTrig;
  int                 txTrig;

  assign rxTrig  = levelThreshold(rxSel, FIFO_DEPTH);
  assign txTrig  = levelThreshold(txSel, FIFO_DEPTH);
  assign rxCond  = int'(rxLevel) >= rxTrig;
  assign txCond  = int'(txLevel) <= txTrig;
  assign rxEvent = rxCond && !rxCondQ;
  assign txEvent = txCond && !txCondQ;

  // Previous trigger conditions; the transmit FIFO is taken as empty out of reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCondQ <= 1'b0;
      txCondQ <= 1'b1;
    end else begin
      rxCondQ <= rxCond;
      txCondQ <= txCond;
    end
  end

  // Sticky status: a new event overrides a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ <= '0;
    end else begin
      rawQ[RX_BIT] <= rxEvent | (rawQ[RX_BIT] & ~strobes.clrVec[RX_BIT]);
      rawQ[TX_BIT] <= txEvent | (rawQ[TX_BIT] & ~strobes.clrVec[TX_BIT]);
      rawQ[RT_BIT] <= strobes.rtSet |
                      (rawQ[RT_BIT] & ~strobes.clrVec[RT_BIT] & ~strobes.rtDrop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (strobes.loadMask) begin
      maskQ <= maskWrData;
    end
  end

  assign rawStatus    = rawQ;
  assign maskOut      = maskQ;
  assign maskedStatus = rawQ & maskQ;
  assign irq          = |(rawQ & maskQ);
  assign txFull       = (int'(txLevel) == FIFO_DEPTH);
  assign txEmpty      = (txLevel == '0);
  assign rxEmpty      = (rxLevel == '0);

endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [SEL_W-1:0]   rxSel,
  input  logic [SEL_W-1:0]   txSel,
  input  logic               rxIdleStrobe,
  input  logic               maskWrEn,
  input  logic [NUM_SRC-1:0] maskWrData,
  input  logic               clrWrEn,
  input  logic [NUM_SRC-1:0] clrWrData,
  output logic [NUM_SRC-1:0] rawStatus,
  output logic [NUM_SRC-1:0] maskOut,
  output logic [NUM_SRC-1:0] maskedStatus,
  output logic               irq,
  output logic               txFull,
  output logic               txEmpty,
  output logic               rxEmpty
);

  irqStrobe_t strobes;

  uart_irq_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .maskWrEn     (maskWrEn),
    .clrWrEn      (clrWrEn),
    .clrWrData    (clrWrData),
    .rxIdleStrobe (rxIdleStrobe),
    .rxLevel      (rxLevel),
    .strobes      (strobes)
  );

  uart_irq_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .maskWrData   (maskWrData),
    .rxLevel      (rxLevel),
    .txLevel      (txLevel),
    .rxSel        (rxSel),
    .txSel        (txSel),
    .rawStatus    (rawStatus),
    .maskOut      (maskOut),
    .maskedStatus (maskedStatus),
    .irq          (irq),
    .txFull       (txFull),
    .txEmpty      (txEmpty),
    .rxEmpty      (rxEmpty)
  );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [LVL_W-1:0]   rxLevel,
  input logic [LVL_W-1:0]   txLevel,
  input logic [SEL_W-1:0]   rxSel,
  input logic [SEL_W-1:0]   txSel,
  input logic               clrWrEn,
  input logic [NUM_SRC-1:0] clrWrData,
  input logic [NUM_SRC-1:0] rawStatus,
  input logic [NUM_SRC-1:0] maskOut,
  input logic               irq,
  input logic               txFull,
  input logic               txEmpty
);

  // R6: a clear of bit 0 with no level or select movement leaves it low.
  assert_rx_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && clrWrEn && clrWrData[RX_BIT] && $stable(rxLevel) && $stable(rxSel))
      |=> !rawStatus[RX_BIT]);

  // R3: the receive-level bit holds without a clear write.
  assert_rx_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rawStatus[RX_BIT] && !clrWrEn) |=> rawStatus[RX_BIT]);

  // R4: the transmit bit only rises after the level or the select moved.
  assert_tx_edge_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus[TX_BIT]) |->
      (($past(txLevel) != $past(txLevel, 2)) || ($past(txSel) != $past(txSel, 2))));

  // R5: an empty receive FIFO drops the timeout bit.
  assert_rt_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |=> !rawStatus[RT_BIT]);

  // R9: a zero mask keeps the request line low.
  assert_mask_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (maskOut == '0) |-> !irq);

  // R10: the transmit FIFO cannot be full and empty at once.
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty));

endmodule

bind uart_irq_unit uart_irq_checker #(.LVL_W(LVL_W)) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rxLevel   (rxLevel),
  .txLevel   (txLevel),
  .rxSel     (rxSel),
  .txSel     (txSel),
  .clrWrEn   (clrWrEn),
  .clrWrData (clrWrData),
  .rawStatus (rawStatus),
  .maskOut   (maskOut),
  .irq       (irq),
  .txFull    (txFull),
  .txEmpty   (txEmpty)
);

// File: tb/test_uart_irq_unit.sv
module test_uart_irq_unit;

  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [LW-1:0] rxLevel = '0, txLevel = '0;
  logic [2:0]    rxSel = '0, txSel = '0;
  logic          rxIdleStrobe = 1'b0, maskWrEn = 1'b0, clrWrEn = 1'b0;
  logic [2:0]    maskWrData = '0, clrWrData = '0;
  logic [2:0]    rawStatus, maskOut, maskedStatus;
  logic          irq, txFull, txEmpty, rxEmpty;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  uart_irq_unit #(.FIFO_DEPTH(DEPTH)) i_uart_irq_unit (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txLevel(txLevel),
    .rxSel(rxSel), .txSel(txSel), .rxIdleStrobe(rxIdleStrobe),
    .maskWrEn(maskWrEn), .maskWrData(maskWrData),
    .clrWrEn(clrWrEn), .clrWrData(clrWrData),
    .rawStatus(rawStatus), .maskOut(maskOut), .maskedStatus(maskedStatus),
    .irq(irq), .txFull(txFull), .txEmpty(txEmpty), .rxEmpty(rxEmpty)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int trigOf(input int sel);
    if (sel == 0) return DEPTH / 8;
    if (sel == 1) return DEPTH / 4;
    if (sel == 2) return DEPTH / 2;
    if (sel == 3) return DEPTH * 3 / 4;
    if (sel == 4) return DEPTH * 7 / 8;
    return DEPTH / 2;
  endfunction

  // Behavioural reference model, advanced at each rising edge.
  int  mRaw, mMask;
  bit  mPrevRx, mPrevTx;
  always @(posedge clk) begin
    if (!rstN) begin
      mRaw = 0; mMask = 0; mPrevRx = 0; mPrevTx = 1;
    end else begin
      bit nowRx, nowTx;
      int clr, setV, keep;
      nowRx = int'(rxLevel) >= trigOf(int'(rxSel));
      nowTx = int'(txLevel) <= trigOf(int'(txSel));
      clr   = clrWrEn ? int'(clrWrData) : 0;
      setV  = 0;
      if (nowRx && !mPrevRx) setV |= 1;
      if (nowTx && !mPrevTx) setV |= 4;
      if (rxIdleStrobe && rxLevel != 0) setV |= 2;
      keep = mRaw & ~clr;
      if (rxLevel == 0) keep &= ~2;
      mRaw = (keep | setV) & 7;
      if (maskWrEn) mMask = int'(maskWrData);
      mPrevRx = nowRx;
      mPrevTx = nowTx;
    end
  end

  // Compare on every falling edge, before new stimulus is applied.
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3,R4,R5,R6,R7", "raw", int'(rawStatus), mRaw);
      check("R11", "mask", int'(maskOut), mMask);
      check("R8", "masked", int'(maskedStatus), mRaw & mMask);
      check("R8", "irq", int'(irq), int'((mRaw & mMask) != 0));
      check("R10", "flags", int'({txFull, txEmpty, rxEmpty}),
            (int'(txLevel) == DEPTH) * 4 + (txLevel == 0) * 2 + (rxLevel == 0));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
    maskWrEn = 1'b0; clrWrEn = 1'b0; rxIdleStrobe = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    tick();
    check("R1", "reset raw", int'(rawStatus), 0);
    check("R1", "reset mask", int'(maskOut), 0);
    check("R1", "reset irq", int'(irq), 0);

    maskWrEn = 1; maskWrData = 3'b111; tick();
    check("R11", "mask loaded", int'(maskOut), 7);
    check("R4", "no tx irq when already low", int'(irq), 0);

    rxLevel = 1; tick();
    check("R2", "rx below 1/8", int'(rawStatus[0]), 0);
    rxLevel = 2; tick();
    check("R3", "rx crossing", int'(rawStatus[0]), 1);
    check("R8", "irq from rx", int'(irq), 1);
    clrWrEn = 1; clrWrData = 3'b001; tick();
    check("R6", "rx cleared", int'(rawStatus[0]), 0);

    rxSel = 4; rxLevel = 13; tick();
    check("R2", "rx below 7/8", int'(rawStatus[0]), 0);
    rxLevel = 14; tick();
    check("R2", "rx at 7/8", int'(rawStatus[0]), 1);
    rxLevel = 0; tick();
    rxLevel = 14; clrWrEn = 1; clrWrData = 3'b001; tick();
    check("R7", "event beats clear", int'(rawStatus[0]), 1);

    clrWrEn = 1; clrWrData = 3'b001; rxLevel = 3; rxIdleStrobe = 1; tick();
    check("R5", "timeout set", int'(rawStatus), 2);
    rxLevel = 0; tick();
    check("R5", "timeout dropped on empty", int'(rawStatus[1]), 0);
    rxIdleStrobe = 1; tick();
    check("R5", "strobe on empty ignored", int'(rawStatus[1]), 0);

    txSel = 1; txLevel = 10; tick();
    txLevel = 5; tick();
    check("R2", "tx above 1/4", int'(rawStatus[2]), 0);
    txLevel = 4; tick();
    check("R4", "tx crossing", int'(rawStatus[2]), 1);

    rxLevel = 3; rxIdleStrobe = 1; tick();
    check("R5", "raw tx+timeout", int'(rawStatus), 6);
    clrWrEn = 1; clrWrData = 3'b100; tick();
    check("R6", "selective clear", int'(rawStatus), 2);

    maskWrEn = 1; maskWrData = 3'b000; tick();
    check("R9", "zero mask irq", int'(irq), 0);
    check("R9", "raw kept", int'(rawStatus), 2);
    maskWrEn = 1; maskWrData = 3'b010; tick();
    check("R8", "masked timeout", int'(maskedStatus), 2);
    check("R8", "irq timeout", int'(irq), 1);
    maskWrEn = 1; maskWrData = 3'b001; tick();
    check("R8", "masked off", int'(irq), 0);

    txLevel = 16; tick();
    check("R10", "tx full", int'({txFull, txEmpty}), 2);
    txLevel = 0; tick();
    check("R10", "tx empty", int'({txFull, txEmpty}), 1);
    check("R10", "rx not empty", int'(rxEmpty), 0);

    rxSel = 6; rxLevel = 0; clrWrEn = 1; clrWrData = 3'b111; tick();
    check("R6", "all cleared", int'(rawStatus), 0);
    rxLevel = 7; tick();
    check("R2", "sel 6 below half", int'(rawStatus[0]), 0);
    rxLevel = 8; tick();
    check("R2", "sel 6 at half", int'(rawStatus[0]), 1);

    for (int i = 0; i < 2000; i++) begin
      rxLevel = LW'($urandom_range(0, DEPTH));
      txLevel = LW'($urandom_range(0, DEPTH));
      if ($urandom_range(0, 7) == 0) rxSel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) txSel = 3'($urandom_range(0, 7));
      rxIdleStrobe = ($urandom_range(0, 3) == 0);
      clrWrEn      = ($urandom_range(0, 2) == 0);
      clrWrData    = 3'($urandom_range(0, 7));
      maskWrEn     = ($urandom_range(0, 9) == 0);
      maskWrData   = 3'($urandom_range(0, 7));
      @(negedge clk);
      #1;
    end
    maskWrEn = 0; clrWrEn = 0; rxIdleStrobe = 0;
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule